// File: doc/BRIEF.md
# Selectable GPIO Interrupt Channel Unit

This unit turns a wide, already synchronised bus of GPIO interrupt sources into a fixed number of interrupt request channels for a parent interrupt controller. Each channel holds a source selector that picks one bit of the bus. It also holds an enable bit and a 2-bit sense field, which chooses rising edge, falling edge, level high or level low. The result of the sense logic is held in a per-channel status bit. Each channel drives an active-high request that a per-channel mask bit can block.

Software configures the unit through a simple word-addressed register port. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the word address. Edge events stay latched until software clears them by writing zero to the status bit. Level events are not latched: the status bit tracks the qualified level. When a channel's selector is rewritten, its edge-history flop is loaded from the newly selected source, so switching sources does not create an edge.

Top module: `gpio_irqsel_unit`

## Requirements
- R1: After reset every register reads 0 and every request output is low; the default sense code 0 means rising edge and all channels start disabled.
- R2: Word addresses are 0-7 for select registers, 8-9 for type registers, 10 for status and 11 for mask; words 12-15 read 0 and writes to them change nothing. Channel n's select byte sits in select word n/4, bits 8*(n%4)+7 down to 8*(n%4): bit 7 is the enable and bits 6:0 are the source index. Every select bit written reads back.
- R3: An enabled channel samples gpio bit number equal to its source index; an index at or beyond the bus width reads as 0.
- R4: Sense code 0 (rising edge): a 0-to-1 change on the selected source sets the status bit on the next clock edge, and the bit stays set after the source falls.
- R5: Sense code 1 (falling edge): a 1-to-0 change sets the status bit on the next clock edge, and the bit stays set after the source rises.
- R6: Sense codes 2 (level high) and 3 (level low): the status bit follows the qualified level one edge later, is not latched, and a status write of 0 does not clear it while the level persists.
- R7: Writing status bit n as 0 clears an edge-mode status bit; writing it as 1 leaves the bit unchanged.
- R8: If a new edge arrives in the same cycle as a clear write to that bit, the bit remains set.
- R9: irq_o[n] is status bit n gated by mask bit n, where a mask bit of 1 blocks the request without changing status.
- R10: When a channel's enable bit is 0 its request is low at once, its status reads 0 from the following edge, and edges on its source are not latched.
- R11: Writing a select byte reloads that channel's edge history from the newly chosen source, so selecting a source that is already high gives no rising edge.
- R12: Channels 0-15 take their sense field from type word 8 and channels 16-31 from type word 9, at bits 2k+1:2k, where k is n modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_src_i | input | SRC_W | Synchronised GPIO interrupt source bus |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | N_CH | Masked active-high request per channel |

## Verification
Two functions can meet in one clock cycle: a software clear of a status bit and the hardware edge that sets the same bit. The bench raises the chosen source of channel 3 on the same falling clock edge at which it places a status write of all zeros. After the next rising edge it reads status and expects bit 3 set, because the new event takes priority over the clear. A second overlap tests a select-byte rewrite against a source that is already high. Here the reloaded history must give no edge, and this is checked by reading the status word one cycle after the write.

// File: rtl/gpio_irqsel_pkg.sv
package gpio_irqsel_pkg;
  localparam int REG_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int CH_PER_SEL = REG_W / BYTE_W;
  localparam int CH_PER_TYP = REG_W / 2;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;
endpackage

// File: rtl/gpio_irqsel_regs.sv
module gpio_irqsel_regs
  import gpio_irqsel_pkg::*;
#(
  parameter int N_CH   = 32,
  parameter int SEL_W  = 7,
  parameter int ADDR_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              rdata_o,
  input  logic [N_CH-1:0]               stat_i,
  output logic [N_CH-1:0]               en_o,
  output logic [N_CH-1:0][SEL_W-1:0]    idx_o,
  output logic [N_CH-1:0][1:0]          sense_o,
  output logic [N_CH-1:0]               mask_o,
  output logic [N_CH-1:0]               load_o,
  output logic [N_CH-1:0][SEL_W-1:0]    load_idx_o,
  output logic [N_CH-1:0]               clr_o
);
  localparam int N_SEL  = N_CH / CH_PER_SEL;
  localparam int N_TYP  = N_CH / CH_PER_TYP;
  localparam int A_TYP  = N_SEL;
  localparam int A_STAT = N_SEL + N_TYP;
  localparam int A_MASK = A_STAT + 1;

  logic [N_SEL-1:0][REG_W-1:0] sel_q;
  logic [N_TYP-1:0][REG_W-1:0] typ_q;
  logic [N_CH-1:0]             mask_q;
  logic [31:0]                 a;

  assign a = 32'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      typ_q  <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      for (int r = 0; r < N_SEL; r++)
        if (a == 32'(r)) sel_q[r] <= wdata_i;
      for (int t = 0; t < N_TYP; t++)
        if (a == 32'(A_TYP + t)) typ_q[t] <= wdata_i;
      if (a == 32'(A_MASK)) mask_q <= wdata_i[N_CH-1:0];
    end
  end

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    localparam int SR = n / CH_PER_SEL;
    localparam int SL = BYTE_W * (n % CH_PER_SEL);
    localparam int TR = n / CH_PER_TYP;
    localparam int TL = 2 * (n % CH_PER_TYP);
    assign en_o[n]       = sel_q[SR][SL+BYTE_W-1];
    assign idx_o[n]      = sel_q[SR][SL +: SEL_W];
    assign sense_o[n]    = typ_q[TR][TL +: 2];
    assign load_o[n]     = we_i && (a == 32'(SR));
    assign load_idx_o[n] = wdata_i[SL +: SEL_W];
    assign clr_o[n]      = we_i && (a == 32'(A_STAT)) && !wdata_i[n];
  end

  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < N_SEL; r++)
      if (a == 32'(r)) rdata_o = sel_q[r];
    for (int t = 0; t < N_TYP; t++)
      if (a == 32'(A_TYP + t)) rdata_o = typ_q[t];
    if (a == 32'(A_STAT)) rdata_o[N_CH-1:0] = stat_i;
    if (a == 32'(A_MASK)) rdata_o[N_CH-1:0] = mask_q;
  end
endmodule

// File: rtl/gpio_irqsel_src_pick.sv
module gpio_irqsel_src_pick #(
  parameter int SRC_W = 128,
  parameter int SEL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_bus_i,
  input  logic [SEL_W-1:0] sel_idx_i,
  input  logic             load_i,
  input  logic [SEL_W-1:0] load_idx_i,
  output logic             cur_o,
  output logic             prev_o
);
  localparam int SPAN = 1 << SEL_W;

  // indices past the bus read as 0
  logic [SPAN-1:0] padded;
  logic            hist_q;

  always_comb begin
    padded = '0;
    for (int i = 0; i < SPAN; i++)
      if (i < SRC_W) padded[i] = src_bus_i[i];
  end

  assign cur_o  = padded[sel_idx_i];
  assign prev_o = hist_q;

  // reload on selector write to avoid a switchover edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= 1'b0;
    else if (load_i) hist_q <= padded[load_idx_i];
    else             hist_q <= cur_o;
  end

  // R11
  reload_hist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (load_idx_i == sel_idx_i) |=> prev_o == $past(cur_o));
endmodule

// File: rtl/gpio_irqsel_detect.sv
module gpio_irqsel_detect
  import gpio_irqsel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sense_i,
  input  logic       cur_i,
  input  logic       prev_i,
  input  logic       clr_i,
  output logic       stat_o
);
  sense_e sense;
  logic   is_lvl, hit_edge, lvl_hit, stat_d, stat_q;

  assign sense  = sense_e'(sense_i);
  assign is_lvl = sense_i[1];

  always_comb begin
    hit_edge = 1'b0;
    lvl_hit  = 1'b0;
    unique case (sense)
      SENSE_RISE: hit_edge = cur_i & ~prev_i;
      SENSE_FALL: hit_edge = ~cur_i & prev_i;
      SENSE_HIGH: lvl_hit  = cur_i;
      SENSE_LOW:  lvl_hit  = ~cur_i;
      default:    hit_edge = 1'b0;
    endcase
  end

  // new edge beats a coincident clear
  always_comb begin
    if (!en_i)       stat_d = 1'b0;
    else if (is_lvl) stat_d = lvl_hit;
    else             stat_d = hit_edge | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R10
  dis_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !stat_o);
  // R4
  rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sense_i == 2'd0 && cur_i && !prev_i |=> stat_o);
  // R5
  fall_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sense_i == 2'd1 && !cur_i && prev_i |=> stat_o);
  // R6
  lvl_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sense_i == 2'd2 |=> stat_o == $past(cur_i));
  // R7
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !sense_i[1] && stat_o && !clr_i |=> stat_o);
  // R7
  clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sense_i == 2'd0 && clr_i && !(cur_i && !prev_i) |=> !stat_o);
endmodule

// File: rtl/gpio_irqsel_unit.sv
module gpio_irqsel_unit
  import gpio_irqsel_pkg::*;
#(
  parameter  int N_CH   = 32,
  parameter  int SRC_W  = 128,
  parameter  int SEL_W  = 7,
  localparam int ADDR_W = $clog2(N_CH / CH_PER_SEL + N_CH / CH_PER_TYP + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  gpio_src_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [N_CH-1:0]            en, mask, load, clr, stat;
  logic [N_CH-1:0][SEL_W-1:0] idx, load_idx;
  logic [N_CH-1:0][1:0]       sense;

  gpio_irqsel_regs #(.N_CH(N_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .stat_i    (stat),
    .en_o      (en),
    .idx_o     (idx),
    .sense_o   (sense),
    .mask_o    (mask),
    .load_o    (load),
    .load_idx_o(load_idx),
    .clr_o     (clr)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic cur, prev;

    gpio_irqsel_src_pick #(.SRC_W(SRC_W), .SEL_W(SEL_W)) u_pick (
      .clk_i, .rst_ni,
      .src_bus_i (gpio_src_i),
      .sel_idx_i (idx[n]),
      .load_i    (load[n]),
      .load_idx_i(load_idx[n]),
      .cur_o     (cur),
      .prev_o    (prev)
    );

    gpio_irqsel_detect u_det (
      .clk_i, .rst_ni,
      .en_i   (en[n]),
      .sense_i(sense[n]),
      .cur_i  (cur),
      .prev_i (prev),
      .clr_i  (clr[n]),
      .stat_o (stat[n])
    );
  end

  assign irq_o = stat & ~mask & en;

  // R9
  mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & mask) == '0);
endmodule

// File: tb/sim_gpio_irqsel_unit.sv
`timescale 1ns/1ps
module sim_gpio_irqsel_unit;
  localparam int A_STAT = 10;
  localparam int A_MASK = 11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src = '0;
  logic         we = 1'b0;
  logic [3:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [31:0]  irq;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_irqsel_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .gpio_src_i(src),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic int sidx(int n);
    return (n * 37 + 11) % 128;
  endfunction

  function automatic int spare_idx();
    for (int b = 0; b < 128; b++) begin
      bit used = 0;
      for (int n = 0; n < 32; n++) if (sidx(n) == b) used = 1;
      if (!used) return b;
    end
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = 4'(a);
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] sel_word(int r);
    logic [31:0] w;
    for (int l = 0; l < 4; l++) w[8*l +: 8] = 8'h80 | 8'(sidx(4*r + l));
    return w;
  endfunction

  task automatic cfg(logic [1:0] mode, bit high);
    logic [31:0] d;
    src = high ? '1 : '0;
    wr(8, {16{mode}});
    wr(9, {16{mode}});
    for (int r = 0; r < 8; r++) wr(r, sel_word(r));
    wr(A_MASK, 32'h0);
    repeat (2) @(negedge clk);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d);
    chk(mode[1] ? "R6 idle" : "R4/R5 idle", d, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, acc;
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, d);
      chk("R1 reg", d, 32'h0);
    end
    chk("R1 irq", irq, 32'h0);

    // R2, R12 readback and unmapped words
    for (int r = 0; r < 8; r++) wr(r, 32'h3C00_0000 ^ (32'h0101_0101 * r));
    wr(8, 32'hDEAD_BEEF);
    wr(9, 32'h1234_5678);
    wr(12, 32'hFFFF_FFFF);
    for (int r = 0; r < 8; r++) begin
      rd(r, d);
      chk("R2 sel", d, 32'h3C00_0000 ^ (32'h0101_0101 * r));
    end
    rd(8, d);  chk("R12 typ0", d, 32'hDEAD_BEEF);
    rd(9, d);  chk("R12 typ1", d, 32'h1234_5678);
    rd(12, d); chk("R2 hole", d, 32'h0);
    rd(A_MASK, d); chk("R2 hole write", d, 32'h0);

    // R4 rising sweep
    cfg(2'd0, 0);
    acc = '0;
    for (int n = 0; n < 32; n++) begin
      @(negedge clk); src[sidx(n)] = 1'b1;
      @(negedge clk); acc[n] = 1'b1;
      rd(A_STAT, d); chk("R4 rise", d, acc);
      chk("R9 irq", irq, acc);
      src[sidx(n)] = 1'b0;
      @(negedge clk);
      rd(A_STAT, d); chk("R4 hold", d, acc);
    end

    // R7 clear semantics
    wr(A_STAT, 32'h5555_5555);
    rd(A_STAT, d); chk("R7 clr0", d, 32'h5555_5555);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R7 keep1", d, 32'h5555_5555);

    // R9 masking
    wr(A_MASK, 32'hF0F0_F0F0);
    chk("R9 masked", irq, 32'h0505_0505);
    rd(A_STAT, d); chk("R9 status", d, 32'h5555_5555);
    wr(A_MASK, 32'h0);

    // R8 edge with coincident clear
    @(negedge clk);
    src[sidx(3)] = 1'b1; we = 1'b1; addr = 4'(A_STAT); wdata = 32'h0;
    @(negedge clk);
    we = 1'b0;
    rd(A_STAT, d); chk("R8 edge wins", d, 32'h0000_0008);

    // R10 disable channels 0..3
    wr(0, {1'b0, 7'(sidx(3)), 1'b0, 7'(sidx(2)), 1'b0, 7'(sidx(1)), 1'b0, 7'(sidx(0))});
    chk("R10 irq now", irq, 32'h0);
    @(negedge clk);
    rd(A_STAT, d); chk("R10 status", d, 32'h0);
    src[sidx(0)] = 1'b1;
    @(negedge clk);
    rd(A_STAT, d); chk("R10 no latch", d, 32'h0);
    chk("R10 no irq", irq, 32'h0);
    rd(0, d);
    chk("R2 disabled byte", d, {1'b0, 7'(sidx(3)), 1'b0, 7'(sidx(2)), 1'b0, 7'(sidx(1)), 1'b0, 7'(sidx(0))});

    // R11 reselect onto a high source
    b = spare_idx();
    src[b] = 1'b1;
    @(negedge clk);
    d = sel_word(2);
    d[7:0] = 8'h80 | 8'(b);
    wr(2, d);
    @(negedge clk);
    rd(A_STAT, d); chk("R11 no edge", d, 32'h0);
    src[b] = 1'b0;
    @(negedge clk);
    src[b] = 1'b1;
    @(negedge clk);
    rd(A_STAT, d); chk("R3 new source", d, 32'h0000_0100);

    // R5 falling sweep
    cfg(2'd1, 1);
    acc = '0;
    for (int n = 0; n < 32; n++) begin
      @(negedge clk); src[sidx(n)] = 1'b0;
      @(negedge clk); acc[n] = 1'b1;
      rd(A_STAT, d); chk("R5 fall", d, acc);
      src[sidx(n)] = 1'b1;
      @(negedge clk);
      rd(A_STAT, d); chk("R5 hold", d, acc);
    end

    // R6 level high sweep
    cfg(2'd2, 0);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk); src[sidx(n)] = 1'b1;
      @(negedge clk);
      rd(A_STAT, d); chk("R6 high", d, 32'h1 << n);
      src[sidx(n)] = 1'b0;
      @(negedge clk);
      rd(A_STAT, d); chk("R6 high off", d, 32'h0);
    end

    // R6 level low sweep
    cfg(2'd3, 1);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk); src[sidx(n)] = 1'b0;
      @(negedge clk);
      rd(A_STAT, d); chk("R6 low", d, 32'h1 << n);
      chk("R6 low irq", irq, 32'h1 << n);
      src[sidx(n)] = 1'b1;
      @(negedge clk);
      rd(A_STAT, d); chk("R6 low off", d, 32'h0);
    end

    // R12 single field in second type word; R6 clear ignored
    wr(9, 32'h2 << 8);
    @(negedge clk);
    rd(A_STAT, d); chk("R12 ch20 field", d, 32'h0010_0000);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R6 clr ignored", d, 32'h0010_0000);
    src[sidx(20)] = 1'b0;
    @(negedge clk);
    rd(A_STAT, d); chk("R6 level drop", d, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule